// File: doc/BRIEF.md
# Double-Buffered Ethernet Frame Buffer Interface

This block sits between a host processor and a simple Ethernet MAC core. It gives the host a memory-mapped window onto four frame buffers: two for transmit and two for receive. The host writes a frame into a transmit buffer as big-endian 32-bit words and stores its byte count in that buffer's length register. It then sets the buffer's busy bit. The block streams the frame out one byte at a time on a valid/ready output and clears busy once the last byte has been accepted. If the host sets a program bit together with busy, the block does not send anything. It reads the first six bytes of that buffer into the station address register instead.

Frames arriving on the byte-stream input go into a free receive buffer, alternating between the two. When a frame has been stored, the block raises the buffer's done flag. The host reads the frame out and then clears the flag. If both receive buffers are full, the incoming frame is discarded. Each side has a one-cycle interrupt pulse, gated by a per-buffer enable bit.

Back-pressure rules:
- The transmit output holds `tx_valid`, `tx_data` and `tx_last` steady until `tx_ready` is seen high.
- The receive input never stalls. `rx_ready` stays high whenever the block is out of reset.

Top module: `pingpong_frame_buf`

## Requirements
- R1: The host address `host_addr` is a word index (byte offset / 4). The buffer windows start at byte offsets 0x0000 (transmit 0), 0x0800 (transmit 1), 0x1000 (receive 0) and 0x1800 (receive 1). Data words start at the window base. A read returns its value in the cycle after `host_rd`. Data words beyond the `DEPTH` words stored per buffer, and unused offsets, read as zero.
- R2: The transmit status word sits at window offset 0x7FC and has these bits:
  - bit 0: busy
  - bit 1: program
  - bit 3: interrupt enable
  - bit 31: a flag that is stored and never changed by the block

  All other bits read as zero. A status write without bit 0 starts nothing.
- R3: The transmit length register sits at window offset 0x7F4. It keeps only the low 16 bits of the written value.
- R4: Setting busy with program clear sends exactly "length" bytes. Byte k is bits [31-8*(k%4) -: 8] of data word k/4. `tx_last` marks the final byte, and busy clears when that byte is accepted. A length of zero sends nothing and clears busy.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R6: Writing busy and program together loads `station_addr` with the buffer's first six bytes (byte 0 lands in bits 47:40). Both bits then clear, and no byte appears on the stream.
- R7: Only one transmit buffer is drained at a time. A buffer that is set busy while the other is sending is served after that frame's last byte, with no interleaving.
- R8: `tx_irq` pulses for one cycle when the block clears busy on a buffer whose enable bit is set. It stays low otherwise.
- R9: A received frame is stored in big-endian words. A partial last word carries its bytes in the top positions and zeros below. The done bit (receive status bit 0, window offset 0x7FC) sets on the frame's last byte.
- R10: A new frame goes to the buffer after the one last filled if that buffer's done bit is clear. Otherwise it goes to the other buffer if that one is free. If both are full, the frame is dropped entirely.
- R11: In the receive status word, bit 3 is the interrupt enable. A host write can clear done but never set it.
- R12: `rx_irq` pulses for one cycle when done sets on a buffer whose enable bit is set.
- R13: `rx_ready` is high whenever the block is out of reset. Bytes beyond a buffer's capacity are discarded without touching the other buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 11 | Host word address (byte offset / 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after `host_rd` |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the frame |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the incoming frame |
| station_addr | output | 48 | Programmed station address |
| tx_irq | output | 1 | Transmit completion pulse |
| rx_irq | output | 1 | Receive completion pulse |

## Verification
The transmit path is tested in four ways:
- A program command, to show that the address load stays off the stream.
- A seven-byte frame held back by a low `tx_ready` and then released under random stalls, which separates correct lane ordering and holding from data that slips.
- A second buffer queued behind that frame, which exposes interleaving.
- A zero-length frame, which exposes a block that sends a spurious byte or never clears busy.

The receive path is tested with:
- Frames of six, three and one bytes, which exercise partial-word packing.
- A frame arriving while both buffers are full, which must be dropped.
- A frame arriving after only the second buffer is freed, which shows that selection skips a full buffer.
- A frame longer than a buffer, which must be clipped without spilling into the neighbouring window.

// File: rtl/fbuf_pkg.sv
`timescale 1ns/1ps
package fbuf_pkg;
  // Word offsets inside a 0x800-byte buffer window.
  localparam logic [8:0] STAT_WORD = 9'h1FF;  // byte offset 0x7FC
  localparam logic [8:0] LEN_WORD  = 9'h1FD;  // byte offset 0x7F4

  typedef enum logic [1:0] {T_IDLE, T_SEND, T_PGM_HI, T_PGM_LO} tx_state_t;

  // Big-endian lane extraction: lane 0 is the most significant byte.
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] lane);
    case (lane)
      2'd0:    return w[31:24];
      2'd1:    return w[23:16];
      2'd2:    return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  // Insert a byte into a big-endian word; lane 0 starts a fresh word.
  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] lane,
                                           input logic [7:0] b);
    case (lane)
      2'd0:    return {b, 24'h0};
      2'd1:    return {w[31:24], b, 16'h0};
      2'd2:    return {w[31:16], b, 8'h0};
      default: return {w[31:8], b};
    endcase
  endfunction
endpackage

// File: rtl/fbuf_ram.sv
`timescale 1ns/1ps
module fbuf_ram #(
  parameter int DEPTH = 64,
  parameter int IW    = $clog2(DEPTH) + 2
) (
  input  logic          clk,
  input  logic          h_we,
  input  logic [IW-1:0] h_idx,
  input  logic [31:0]   h_wdata,
  output logic [31:0]   h_rdata,
  input  logic          r_we,
  input  logic [IW-1:0] r_idx,
  input  logic [31:0]   r_wdata,
  input  logic [IW-1:0] t_idx,
  output logic [31:0]   t_rdata
);
  localparam int WORDS = 4 * DEPTH;

  logic [31:0] mem [WORDS];

  // The receive engine has priority over the host on a collision.
  always_ff @(posedge clk) begin
    if (h_we) mem[h_idx] <= h_wdata;
    if (r_we) mem[r_idx] <= r_wdata;
  end

  assign h_rdata = mem[h_idx];
  assign t_rdata = mem[t_idx];
endmodule

// File: rtl/fbuf_tx.sv
`timescale 1ns/1ps
module fbuf_tx import fbuf_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       st_we,
  input  logic [3:0]       st_bits,   // {keep, ie, prog, busy}
  input  logic [1:0]       len_we,
  input  logic [15:0]      len_in,
  output logic [1:0][31:0] stat_word,
  output logic [1:0][15:0] len_word,
  output logic [AW:0]      rd_idx,
  input  logic [31:0]      rd_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic [47:0]      station_addr,
  output logic             tx_irq
);
  localparam logic [13:0] DEPTH_W = 14'(DEPTH);

  tx_state_t        state_q;
  logic [1:0]       busy_q, prog_q, ie_q, keep_q;
  logic [1:0][15:0] len_q;
  logic             sel_q, turn_q, irq_q;
  logic [15:0]      cnt_q;
  logic [31:0]      hi_q;
  logic [47:0]      sta_q;

  logic             have, pick, fin, done_evt, in_range;
  logic [15:0]      cur_len;
  logic [AW-1:0]    word;

  always_comb begin
    have     = |busy_q;
    pick     = busy_q[turn_q] ? turn_q : ~turn_q;
    cur_len  = len_q[sel_q];
    in_range = cnt_q[15:2] < DEPTH_W;
    tx_valid = (state_q == T_SEND) && (cur_len != 16'd0);
    tx_last  = (cnt_q == cur_len - 16'd1);
    tx_data  = in_range ? lane_byte(rd_data, cnt_q[1:0]) : 8'h00;
    fin      = (state_q == T_SEND) && ((cur_len == 16'd0) || (tx_ready && tx_last));
    done_evt = fin || (state_q == T_PGM_LO);
    case (state_q)
      T_PGM_HI: word = AW'(0);
      T_PGM_LO: word = AW'(1);
      default:  word = cnt_q[AW+1:2];
    endcase
    rd_idx = {sel_q, word};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      busy_q  <= '0;
      prog_q  <= '0;
      ie_q    <= '0;
      keep_q  <= '0;
      len_q   <= '0;
      sel_q   <= 1'b0;
      turn_q  <= 1'b0;
      cnt_q   <= '0;
      hi_q    <= '0;
      sta_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= done_evt && ie_q[sel_q];
      for (int i = 0; i < 2; i++) begin
        if (st_we[i]) begin
          busy_q[i] <= st_bits[0];
          prog_q[i] <= st_bits[1];
          ie_q[i]   <= st_bits[2];
          keep_q[i] <= st_bits[3];
        end
        if (len_we[i]) len_q[i] <= len_in;
        if (done_evt && (sel_q == 1'(i))) begin
          busy_q[i] <= 1'b0;
          prog_q[i] <= 1'b0;
        end
      end
      case (state_q)
        T_IDLE: if (have) begin
          sel_q   <= pick;
          cnt_q   <= '0;
          state_q <= prog_q[pick] ? T_PGM_HI : T_SEND;
        end
        T_PGM_HI: begin
          hi_q    <= rd_data;
          state_q <= T_PGM_LO;
        end
        T_PGM_LO: begin
          sta_q   <= {hi_q, rd_data[31:16]};
          turn_q  <= ~sel_q;
          state_q <= T_IDLE;
        end
        T_SEND: begin
          if (tx_valid && tx_ready) cnt_q <= cnt_q + 16'd1;
          if (fin) begin
            turn_q  <= ~sel_q;
            state_q <= T_IDLE;
          end
        end
        default: state_q <= T_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_stat
    assign stat_word[g] = {keep_q[g], 27'b0, ie_q[g], 1'b0, prog_q[g], busy_q[g]};
    assign len_word[g]  = len_q[g];
  end

  assign station_addr = sta_q;
  assign tx_irq       = irq_q;

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R5
  AST_TX_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid); // R4
  AST_TX_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R8
endmodule

// File: rtl/fbuf_rx.sv
`timescale 1ns/1ps
module fbuf_rx import fbuf_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       st_we,
  input  logic             keep_done,  // host written bit 0
  input  logic             ie_in,      // host written bit 3
  output logic [1:0][31:0] stat_word,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             ram_we,
  output logic [AW:0]      ram_idx,
  output logic [31:0]      ram_wdata,
  output logic             rx_irq
);
  localparam logic [13:0] DEPTH_W = 14'(DEPTH);

  logic [1:0]  done_q, ie_q;
  logic        turn_q, in_frame_q, tgt_q, drop_q, irq_q, rdy_q;
  logic [15:0] cnt_q;
  logic [31:0] acc_q;

  logic        beat, ok, pick, cur_tgt, cur_drop;
  logic [31:0] new_word;

  always_comb begin
    beat     = rx_valid && rdy_q;
    ok       = ~(done_q[0] & done_q[1]);
    pick     = done_q[turn_q] ? ~turn_q : turn_q;
    cur_tgt  = in_frame_q ? tgt_q : pick;
    cur_drop = in_frame_q ? drop_q : ~ok;
    new_word = lane_put(acc_q, cnt_q[1:0], rx_data);
    ram_we   = beat && !cur_drop && ((cnt_q[1:0] == 2'd3) || rx_last)
               && (cnt_q[15:2] < DEPTH_W);
    ram_idx  = {cur_tgt, cnt_q[AW+1:2]};
    ram_wdata = new_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q     <= '0;
      ie_q       <= '0;
      turn_q     <= 1'b0;
      in_frame_q <= 1'b0;
      tgt_q      <= 1'b0;
      drop_q     <= 1'b0;
      cnt_q      <= '0;
      acc_q      <= '0;
      irq_q      <= 1'b0;
      rdy_q      <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      irq_q <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        if (st_we[i]) begin
          done_q[i] <= done_q[i] & keep_done;
          ie_q[i]   <= ie_in;
        end
      end
      if (beat) begin
        acc_q      <= new_word;
        in_frame_q <= !rx_last;
        if (!in_frame_q) begin
          tgt_q  <= pick;
          drop_q <= ~ok;
        end
        if (rx_last) cnt_q <= '0;
        else if (cnt_q != 16'hFFFF) cnt_q <= cnt_q + 16'd1;
        if (rx_last && !cur_drop) begin
          done_q[cur_tgt] <= 1'b1;
          turn_q          <= ~cur_tgt;
          irq_q           <= ie_q[cur_tgt];
        end
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_stat
    assign stat_word[g] = {28'b0, ie_q[g], 2'b0, done_q[g]};
  end

  assign rx_ready = rdy_q;
  assign rx_irq   = irq_q;

  AST_RX_DONE0_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q[0]) |-> $past(rx_valid && rx_ready && rx_last)); // R9
  AST_RX_DONE1_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q[1]) |-> $past(rx_valid && rx_ready && rx_last)); // R9
  AST_RX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> ($rose(done_q[0]) || $rose(done_q[1]))); // R12
endmodule

// File: rtl/pingpong_frame_buf.sv
`timescale 1ns/1ps
module pingpong_frame_buf import fbuf_pkg::*; #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [10:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic [47:0] station_addr,
  output logic        tx_irq,
  output logic        rx_irq
);
  localparam int         AW      = $clog2(DEPTH);
  localparam int         IW      = AW + 2;
  localparam logic [8:0] DEPTH_L = 9'(DEPTH);

  logic [1:0]       win;
  logic [8:0]       woff;
  logic             data_hit, is_stat, is_len;
  logic [1:0]       tx_st_we, tx_len_we, rx_st_we;
  logic [1:0][31:0] tx_stat, rx_stat;
  logic [1:0][15:0] tx_len;
  logic [31:0]      h_rdata, t_rdata, r_wdata, rd_val;
  logic [AW:0]      t_idx, r_idx;
  logic             r_we;

  always_comb begin
    win      = host_addr[10:9];
    woff     = host_addr[8:0];
    data_hit = woff < DEPTH_L;
    is_stat  = woff == STAT_WORD;
    is_len   = woff == LEN_WORD;
    for (int i = 0; i < 2; i++) begin
      tx_st_we[i]  = host_wr && is_stat && (win == {1'b0, 1'(i)});
      tx_len_we[i] = host_wr && is_len  && (win == {1'b0, 1'(i)});
      rx_st_we[i]  = host_wr && is_stat && (win == {1'b1, 1'(i)});
    end
    if (data_hit)          rd_val = h_rdata;
    else if (is_stat)      rd_val = win[1] ? rx_stat[win[0]] : tx_stat[win[0]];
    else if (is_len && !win[1]) rd_val = {16'h0, tx_len[win[0]]};
    else                   rd_val = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_val;
  end

  fbuf_ram #(.DEPTH(DEPTH), .IW(IW)) u_ram (
    .clk     (clk),
    .h_we    (host_wr && data_hit),
    .h_idx   ({win, woff[AW-1:0]}),
    .h_wdata (host_wdata),
    .h_rdata (h_rdata),
    .r_we    (r_we),
    .r_idx   ({1'b1, r_idx}),
    .r_wdata (r_wdata),
    .t_idx   ({1'b0, t_idx}),
    .t_rdata (t_rdata)
  );

  fbuf_tx #(.DEPTH(DEPTH), .AW(AW)) u_tx (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_we        (tx_st_we),
    .st_bits      ({host_wdata[31], host_wdata[3], host_wdata[1], host_wdata[0]}),
    .len_we       (tx_len_we),
    .len_in       (host_wdata[15:0]),
    .stat_word    (tx_stat),
    .len_word     (tx_len),
    .rd_idx       (t_idx),
    .rd_data      (t_rdata),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .tx_data      (tx_data),
    .tx_last      (tx_last),
    .station_addr (station_addr),
    .tx_irq       (tx_irq)
  );

  fbuf_rx #(.DEPTH(DEPTH), .AW(AW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_we     (rx_st_we),
    .keep_done (host_wdata[0]),
    .ie_in     (host_wdata[3]),
    .stat_word (rx_stat),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .rx_last   (rx_last),
    .ram_we    (r_we),
    .ram_idx   (r_idx),
    .ram_wdata (r_wdata),
    .rx_irq    (rx_irq)
  );
endmodule

// File: tb/pingpong_frame_buf_bench.sv
`timescale 1ns/1ps
module pingpong_frame_buf_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [10:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tx_valid, tx_last, rx_ready, tx_irq, rx_irq;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [47:0] station_addr;

  int tests = 0, fails = 0;
  int tx_irq_cnt = 0, rx_irq_cnt = 0;
  int rdy_mode = 1;           // 0 low, 1 high, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0] exp_q[$];       // {last, byte}
  bit finished = 0;

  always #2.5 clk = ~clk;

  pingpong_frame_buf u_pingpong_frame_buf (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .station_addr(station_addr), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Reference stream model: every accepted byte is compared with the queue head.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_irq) tx_irq_cnt++;
      if (rx_irq) rx_irq_cnt++;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk("R4 unexpected tx byte", {1'b1, tx_last, tx_data}, 0);
        else chk("R4 tx byte/last", {tx_last, tx_data}, exp_q.pop_front());
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tx_ready = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lfsr[0] : 1'b0;
    end
  end

  task automatic hwrite(input logic [12:0] ba, input logic [31:0] d);
    host_wr = 1'b1; host_addr = ba[12:2]; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [12:0] ba, output logic [31:0] d);
    host_rd = 1'b1; host_addr = ba[12:2];
    @(posedge clk); #1;
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [12:0] ba, input logic [31:0] exp);
    logic [31:0] d;
    hread(ba, d);
    chk(req, d, exp);
  endtask

  task automatic wait_idle(input logic [12:0] stat_ba);
    logic [31:0] d;
    for (int n = 0; n < 2000; n++) begin
      hread(stat_ba, d);
      if (d[1:0] == 2'b00) return;
    end
    chk("R4 busy never cleared", 1, 0);
  endtask

  task automatic push_frame(input logic [7:0] b[$]);
    for (int k = 0; k < b.size(); k++) exp_q.push_back({k == b.size() - 1, b[k]});
  endtask

  task automatic rx_frame(input logic [7:0] b[$]);
    for (int k = 0; k < b.size(); k++) begin
      chk("R13 rx_ready high", rx_ready, 1);
      rx_valid = 1'b1; rx_data = b[k]; rx_last = (k == b.size() - 1);
      @(posedge clk); #1;
    end
    rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] big[$];
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // Reset state
    chk("R4 reset tx_valid", tx_valid, 0);
    chk("R8 reset tx_irq", tx_irq, 0);
    chk("R12 reset rx_irq", rx_irq, 0);
    chk("R13 reset rx_ready", rx_ready, 1);
    chk("R6 reset station", station_addr, 0);
    rd_chk("R2 reset tx status", 13'h07FC, 32'h0);

    // R1 address map
    hwrite(13'h0804, 32'hCAFEF00D);
    rd_chk("R1 tx1 data word", 13'h0804, 32'hCAFEF00D);
    rd_chk("R1 beyond capacity", 13'h0400, 32'h0);

    // R6 program command
    hwrite(13'h0000, 32'h000A3500);
    hwrite(13'h0004, 32'h22010000);
    hwrite(13'h07FC, 32'h0000000B);
    wait_idle(13'h07FC);
    chk("R6 station address", station_addr, 48'h000A35002201);
    chk("R8 irq after program", tx_irq_cnt, 1);
    rd_chk("R2 status after program", 13'h07FC, 32'h00000008);

    // R3/R4/R5/R7: frame A in buf0 held, B queued in buf1
    hwrite(13'h0000, 32'hA0A1A2A3);
    hwrite(13'h0004, 32'hA4A5A6FF);
    hwrite(13'h07F4, 32'hABCD0007);
    rd_chk("R3 length low half", 13'h07F4, 32'h00000007);
    push_frame('{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'hA6});
    rdy_mode = 0;
    @(posedge clk); #1;
    hwrite(13'h07FC, 32'h00000001);
    repeat (3) @(posedge clk); #1;
    chk("R5 valid held", {tx_valid, tx_data}, {1'b1, 8'hA0});
    hwrite(13'h0800, 32'hB0B1B2B3);
    hwrite(13'h0FF4, 32'h00000003);
    push_frame('{8'hB0, 8'hB1, 8'hB2});
    hwrite(13'h0FFC, 32'h00000009);
    chk("R5 still held", {tx_valid, tx_data, tx_last}, {1'b1, 8'hA0, 1'b0});
    chk("R7 no second stream", exp_q.size(), 10);
    rdy_mode = 2;
    wait_idle(13'h07FC);
    wait_idle(13'h0FFC);
    repeat (3) @(posedge clk); #1;
    chk("R7 all bytes in order", exp_q.size(), 0);
    chk("R8 irq only for enabled buffer", tx_irq_cnt, 2);
    rdy_mode = 1;

    // R4 zero length
    hwrite(13'h07F4, 32'h0);
    hwrite(13'h07FC, 32'h00000009);
    wait_idle(13'h07FC);
    repeat (2) @(posedge clk); #1;
    chk("R4 zero length irq", tx_irq_cnt, 3);
    chk("R4 zero length no bytes", exp_q.size(), 0);

    // R2 storage-only bit and program without busy
    hwrite(13'h0FFC, 32'h8000000A);
    repeat (4) @(posedge clk); #1;
    rd_chk("R2 keep bit stored", 13'h0FFC, 32'h8000000A);
    chk("R2 no action without busy", {tx_valid, station_addr}, {1'b0, 48'h000A35002201});
    hwrite(13'h0FFC, 32'h0);

    // R9/R10/R11/R12 receive
    hwrite(13'h17FC, 32'h8);
    hwrite(13'h1FFC, 32'h8);
    rx_frame('{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66});
    rd_chk("R9 rx0 word0", 13'h1000, 32'h11223344);
    rd_chk("R9 rx0 partial word", 13'h1004, 32'h55660000);
    rd_chk("R11 rx0 status", 13'h17FC, 32'h9);
    chk("R12 rx irq count", rx_irq_cnt, 1);
    rx_frame('{8'h77, 8'h88, 8'h99});
    rd_chk("R10 second frame in rx1", 13'h1800, 32'h77889900);
    rd_chk("R10 rx1 status", 13'h1FFC, 32'h9);
    rx_frame('{8'hCC, 8'hDD});
    rd_chk("R10 drop keeps rx0", 13'h1000, 32'h11223344);
    rd_chk("R10 drop keeps rx1", 13'h1800, 32'h77889900);
    chk("R12 no irq on drop", rx_irq_cnt, 2);
    hwrite(13'h1FFC, 32'h8);
    rd_chk("R11 done cleared", 13'h1FFC, 32'h8);
    hwrite(13'h1FFC, 32'h9);
    rd_chk("R11 host cannot set done", 13'h1FFC, 32'h8);
    rx_frame('{8'hEE});
    rd_chk("R10 skip full rx0", 13'h1800, 32'hEE000000);
    rd_chk("R10 rx0 still done", 13'h17FC, 32'h9);

    // R13 oversize frame into rx0, interrupts disabled
    hwrite(13'h17FC, 32'h0);
    for (int k = 0; k < 260; k++) big.push_back(8'(k));
    rx_frame(big);
    rd_chk("R13 last stored word", 13'h10FC, 32'hFCFDFEFF);
    rd_chk("R13 neighbour untouched", 13'h1800, 32'hEE000000);
    rd_chk("R9 oversize done set", 13'h17FC, 32'h1);
    chk("R12 no irq when disabled", rx_irq_cnt, 3);
    chk("R4 no stray tx bytes", exp_q.size(), 0);
    summary();
  end
endmodule